// File: doc/BRIEF.md
# Video Timing and Subcarrier Reset Controller

This block holds the standard-definition (SD) raster counters: sample within line, line within frame, and a field number. It also holds a colour-subcarrier phase accumulator and a separate high-definition (HD) raster counter set. A single external sync pin restarts these in different ways. A 2-bit mode input selects what the pin means. In one mode, a pin pulse freezes the SD raster at its origin and restarts it at field 1, and the subcarrier phase restarts with it. In another mode, a pin pulse leaves the raster running and zeroes the subcarrier phase at the start of the next field. In the remaining two modes the pin has no effect on this logic. The HD counters have their own level-sensitive hold bit and never react to the pin.

The pin is asynchronous. It passes through a two-flop synchronizer and is then edge-detected. A pulse is recognized if it is high at one or more clock edges. The line count per frame depends on the selected standard, and the field cycle is 8 fields for PAL and 4 fields for NTSC. The phase accumulator adds a programmable step on every clock. There is no streaming data path: every pin is a plain control or status signal.

Top module: `vtr_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, the SD sample and line counts read 0, the field number reads 1, the subcarrier phase reads 0, and both HD counts read 0.
- R2: When it is not held, the SD sample count runs 0 to SD_PIX-1 and then wraps. The line count steps when the sample count wraps, and it wraps after the last line of the frame. The last line is PAL_LINES-1 when `pal_sel`=1 and NTSC_LINES-1 when `pal_sel`=0.
- R3: The field number advances when the sample count wraps on two lines: the last line of the first field, which is line (L+1)/2-1 for L lines per frame, and the last line of the frame. It counts 1..8 when `pal_sel`=1 and 1..4 when `pal_sel`=0, and then returns to 1.
- R4: The phase output adds `phase_step` modulo 2^32 on every clock, except on a clock where R5, R6 or R8 clears it.
- R5: With `pin_mode`=2'b10, let edge n be the first clock edge at which `sync_pin` is sampled high after being low. From the state after edge n+3, the SD sample and line counts read 0, the field number reads 1 and the phase reads 0. This lasts for as long as the pin keeps being sampled high.
- R6: After the R5 hold, let edge m be the first edge at which the pin is sampled low. The held state is still shown after edge m+2. After edge m+3 the sample count reads 1, the field reads 1 and the phase equals one `phase_step`, and counting continues normally from there.
- R7: A `sync_pin` pulse that is high at only one clock edge is still recognized in mode 2'b10. The held state appears once, after edge n+3, and counting resumes after edge n+4.
- R8: With `pin_mode`=2'b01, a rising pin edge does not touch the SD counters. The phase reads 0 in the first state that shows the next field number, and the field number there is the previous one plus 1, wrapping at the R3 limit. After that the phase accumulates again.
- R9: With `pin_mode`=2'b00 or 2'b11, pin activity does not change the SD counters or the phase.
- R10: While `hd_hold`=1, the HD sample and line counts read 0 from the next clock. When it is 0, the HD sample count runs 0..HD_PIX-1 and the line count runs 0..HD_LINES-1.
- R11: `hd_hold` has no effect on the SD counters or the phase, and the sync pin has no effect on the HD counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_sel | input | 1 | 1 = PAL frame length and 8-field cycle, 0 = NTSC frame length and 4-field cycle |
| pin_mode | input | 2 | Sync pin meaning: 00 off, 01 phase clear at next field, 10 timing hold, 11 frequency-lock (no effect here) |
| sync_pin | input | 1 | Asynchronous external sync pin |
| hd_hold | input | 1 | Holds the HD counters at 0 while 1 |
| phase_step | input | PHASE_W | Phase increment added every clock |
| sd_pix | output | SD_HW | SD sample within line |
| sd_line | output | SD_VW | SD line within frame |
| sd_field | output | 4 | SD field number, 1-based |
| sc_phase | output | PHASE_W | Subcarrier phase accumulator |
| hd_pix | output | HD_HW | HD sample within line |
| hd_line | output | HD_VW | HD line within frame |

## Verification
The raster is first left free-running in NTSC and then in PAL. This separates the two frame lengths and the 4- and 8-field wrap, and a phase step large enough to overflow 32 bits shows the modulo behaviour. The pin is then pulsed in all four modes. Long holds and single-edge pulses in timing-hold mode show the exact onset and release cycles. A pulse in phase-clear mode, placed early in a field, shows that the clear waits for the field change while the field count keeps running. The same pulses in the off and frequency-lock modes must leave the phase arithmetic intact. Toggling the HD hold bit during SD activity, and holding the SD raster while HD runs, tells the two counter sets apart.

// File: rtl/vtr_pkg.sv
package vtr_pkg;
  typedef enum logic [1:0] {
    PIN_OFF       = 2'b00,
    PIN_PHASE_CLR = 2'b01,
    PIN_TIMING    = 2'b10,
    PIN_FREQ_LOCK = 2'b11
  } pin_mode_e;

  localparam int FIELD_W = 4;
  localparam logic [FIELD_W-1:0] PAL_FIELDS  = 4'd8;
  localparam logic [FIELD_W-1:0] NTSC_FIELDS = 4'd4;
endpackage

// File: rtl/vtr_pin_sync.sv
module vtr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_lvl,
  output logic pin_rise
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], pin_async};
  end

  assign pin_lvl  = shreg[STAGES-1];
  assign pin_rise = shreg[STAGES-1] & ~shreg[STAGES];

  assert_rise_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> !pin_rise);
endmodule

// File: rtl/vtr_sd_timing.sv
module vtr_sd_timing
  import vtr_pkg::*;
#(
  parameter int SD_PIX     = 864,
  parameter int PAL_LINES  = 625,
  parameter int NTSC_LINES = 525,
  parameter int HW = $clog2(SD_PIX),
  parameter int VW = $clog2(PAL_LINES > NTSC_LINES ? PAL_LINES : NTSC_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pal_sel,
  input  logic               hold,
  output logic [HW-1:0]      pix,
  output logic [VW-1:0]      line,
  output logic [FIELD_W-1:0] field,
  output logic               field_start
);
  localparam logic [HW-1:0] PIX_LAST  = HW'(SD_PIX - 1);
  localparam logic [VW-1:0] PAL_LAST  = VW'(PAL_LINES - 1);
  localparam logic [VW-1:0] PAL_MID   = VW'((PAL_LINES + 1) / 2 - 1);
  localparam logic [VW-1:0] NTSC_LAST = VW'(NTSC_LINES - 1);
  localparam logic [VW-1:0] NTSC_MID  = VW'((NTSC_LINES + 1) / 2 - 1);

  logic [VW-1:0]      line_last, line_mid;
  logic [FIELD_W-1:0] fld_last;
  logic               eol, eof;

  always_comb begin
    line_last   = pal_sel ? PAL_LAST : NTSC_LAST;
    line_mid    = pal_sel ? PAL_MID  : NTSC_MID;
    fld_last    = pal_sel ? PAL_FIELDS : NTSC_FIELDS;
    eol         = (pix == PIX_LAST);
    eof         = eol && (line >= line_last);
    field_start = !hold && eol && ((line == line_mid) || (line >= line_last));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix   <= '0;
      line  <= '0;
      field <= FIELD_W'(1);
    end else if (hold) begin
      pix   <= '0;
      line  <= '0;
      field <= FIELD_W'(1);
    end else begin
      pix <= eol ? '0 : pix + 1'b1;
      if (eol) line <= eof ? '0 : line + 1'b1;
      if (field_start) field <= (field >= fld_last) ? FIELD_W'(1) : field + 1'b1;
    end
  end

  assert_sd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (pix == '0 && line == '0 && field == FIELD_W'(1)));
  assert_field_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (field != '0) && (field <= PAL_FIELDS));
  assert_field_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !field_start) |=> $stable(field));
endmodule

// File: rtl/vtr_sc_phase.sv
module vtr_sc_phase #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic               arm_evt,
  input  logic               field_start,
  input  logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] phase
);
  logic armed;
  logic clr;

  assign clr = hold | (armed & field_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      phase <= '0;
    end else begin
      armed <= arm_evt | (armed & ~field_start & ~hold);
      phase <= clr ? '0 : phase + step;
    end
  end

  assert_scr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && field_start) |=> (phase == '0));
  assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !field_start) |=> (phase == $past(phase) + $past(step)));
  assert_hold_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (phase == '0));
endmodule

// File: rtl/vtr_hd_timing.sv
module vtr_hd_timing #(
  parameter int HD_PIX   = 2200,
  parameter int HD_LINES = 1125,
  parameter int HW = $clog2(HD_PIX),
  parameter int VW = $clog2(HD_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  output logic [HW-1:0] pix,
  output logic [VW-1:0] line
);
  localparam logic [HW-1:0] PIX_LAST  = HW'(HD_PIX - 1);
  localparam logic [VW-1:0] LINE_LAST = VW'(HD_LINES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix  <= '0;
      line <= '0;
    end else if (hold) begin
      pix  <= '0;
      line <= '0;
    end else begin
      pix <= (pix == PIX_LAST) ? '0 : pix + 1'b1;
      if (pix == PIX_LAST) line <= (line == LINE_LAST) ? '0 : line + 1'b1;
    end
  end

  assert_hd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (pix == '0 && line == '0));
  assert_hd_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && pix != PIX_LAST) |=> (pix == $past(pix) + 1'b1));
endmodule

// File: rtl/vtr_reset_ctrl.sv
module vtr_reset_ctrl
  import vtr_pkg::*;
#(
  parameter int SD_PIX      = 864,
  parameter int PAL_LINES   = 625,
  parameter int NTSC_LINES  = 525,
  parameter int HD_PIX      = 2200,
  parameter int HD_LINES    = 1125,
  parameter int PHASE_W     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int SD_HW = $clog2(SD_PIX),
  parameter int SD_VW = $clog2(PAL_LINES > NTSC_LINES ? PAL_LINES : NTSC_LINES),
  parameter int HD_HW = $clog2(HD_PIX),
  parameter int HD_VW = $clog2(HD_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pal_sel,
  input  logic [1:0]         pin_mode,
  input  logic               sync_pin,
  input  logic               hd_hold,
  input  logic [PHASE_W-1:0] phase_step,
  output logic [SD_HW-1:0]   sd_pix,
  output logic [SD_VW-1:0]   sd_line,
  output logic [3:0]         sd_field,
  output logic [PHASE_W-1:0] sc_phase,
  output logic [HD_HW-1:0]   hd_pix,
  output logic [HD_VW-1:0]   hd_line
);
  pin_mode_e mode;
  logic pin_lvl, pin_rise;
  logic tr_sel, scr_sel;
  logic sd_hold_q;
  logic fstart;

  assign mode    = pin_mode_e'(pin_mode);
  assign tr_sel  = (mode == PIN_TIMING);
  assign scr_sel = (mode == PIN_PHASE_CLR);

  vtr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(sync_pin),
    .pin_lvl(pin_lvl), .pin_rise(pin_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_hold_q <= 1'b0;
    else        sd_hold_q <= tr_sel & (pin_rise | (sd_hold_q & pin_lvl));
  end

  vtr_sd_timing #(
    .SD_PIX(SD_PIX), .PAL_LINES(PAL_LINES), .NTSC_LINES(NTSC_LINES),
    .HW(SD_HW), .VW(SD_VW)
  ) u_sd (
    .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .hold(sd_hold_q),
    .pix(sd_pix), .line(sd_line), .field(sd_field), .field_start(fstart)
  );

  vtr_sc_phase #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .hold(sd_hold_q),
    .arm_evt(scr_sel & pin_rise), .field_start(fstart),
    .step(phase_step), .phase(sc_phase)
  );

  vtr_hd_timing #(
    .HD_PIX(HD_PIX), .HD_LINES(HD_LINES), .HW(HD_HW), .VW(HD_VW)
  ) u_hd (
    .clk(clk), .rst_n(rst_n), .hold(hd_hold), .pix(hd_pix), .line(hd_line)
  );

  assert_pin_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tr_sel |=> !sd_hold_q);
  assert_hold_onset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_sel && pin_rise) |=> sd_hold_q);
  assert_hold_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_lvl |=> !sd_hold_q);
endmodule

// File: tb/tb_vtr_reset_ctrl.sv
module tb_vtr_reset_ctrl;
  localparam int PIX = 4, PAL = 11, NTSC = 9, HPIX = 5, HLIN = 3;
  localparam int SD_HW = $clog2(PIX);
  localparam int SD_VW = $clog2(PAL);
  localparam int HD_HW = $clog2(HPIX);
  localparam int HD_VW = $clog2(HLIN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pal_sel = 1'b0;
  logic [1:0] pin_mode = 2'b00;
  logic sync_pin = 1'b0;
  logic hd_hold = 1'b0;
  logic [31:0] phase_step = 32'h0;
  logic [SD_HW-1:0] sd_pix;
  logic [SD_VW-1:0] sd_line;
  logic [3:0] sd_field;
  logic [31:0] sc_phase;
  logic [HD_HW-1:0] hd_pix;
  logic [HD_VW-1:0] hd_line;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vtr_reset_ctrl #(
    .SD_PIX(PIX), .PAL_LINES(PAL), .NTSC_LINES(NTSC),
    .HD_PIX(HPIX), .HD_LINES(HLIN)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .pin_mode(pin_mode),
    .sync_pin(sync_pin), .hd_hold(hd_hold), .phase_step(phase_step),
    .sd_pix(sd_pix), .sd_line(sd_line), .sd_field(sd_field),
    .sc_phase(sc_phase), .hd_pix(hd_pix), .hd_line(hd_line)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_pix, m_line, m_fld, m_hp, m_hl;
  bit [31:0] m_ph;
  bit m_act, m_arm;
  bit pin_hist[$] = '{0, 0, 0};
  int last_l, mid_l, nfld;
  bit lvl_o, rise_o, fst, clr, nxt_act, nxt_arm;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pix = 0; m_line = 0; m_fld = 1; m_ph = 0; m_act = 0; m_arm = 0;
      m_hp = 0; m_hl = 0;
      pin_hist = '{0, 0, 0};
    end else begin
      lvl_o  = pin_hist[1];
      rise_o = pin_hist[1] && !pin_hist[2];
      last_l = pal_sel ? PAL - 1 : NTSC - 1;
      mid_l  = pal_sel ? (PAL + 1) / 2 - 1 : (NTSC + 1) / 2 - 1;
      nfld   = pal_sel ? 8 : 4;
      fst = !m_act && (m_pix == PIX - 1) && (m_line == mid_l || m_line >= last_l);
      clr = m_act || (m_arm && fst);
      nxt_arm = (pin_mode == 2'b01 && rise_o) || (m_arm && !fst && !m_act);
      nxt_act = (pin_mode == 2'b10) && (rise_o || (m_act && lvl_o));
      if (m_act) begin
        m_pix = 0; m_line = 0; m_fld = 1;
      end else begin
        if (fst) m_fld = (m_fld >= nfld) ? 1 : m_fld + 1;
        if (m_pix == PIX - 1) begin
          m_pix = 0;
          m_line = (m_line >= last_l) ? 0 : m_line + 1;
        end else m_pix = m_pix + 1;
      end
      m_ph = clr ? 32'h0 : m_ph + phase_step;
      if (hd_hold) begin
        m_hp = 0; m_hl = 0;
      end else if (m_hp == HPIX - 1) begin
        m_hp = 0; m_hl = (m_hl == HLIN - 1) ? 0 : m_hl + 1;
      end else m_hp = m_hp + 1;
      m_act = nxt_act;
      m_arm = nxt_arm;
      pin_hist.push_front(sync_pin);
      void'(pin_hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "sd_pix", sd_pix, m_pix);
      chk("R2", "sd_line", sd_line, m_line);
      chk("R3", "sd_field", sd_field, m_fld);
      chk("R4", "sc_phase", sc_phase, m_ph);
      chk("R10", "hd_pix", hd_pix, m_hp);
      chk("R10", "hd_line", hd_line, m_hl);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint ph0, f0, nf;
    repeat (3) @(negedge clk);
    chk("R1", "sd_pix in reset", sd_pix, 0);
    chk("R1", "sd_line in reset", sd_line, 0);
    chk("R1", "sd_field in reset", sd_field, 1);
    chk("R1", "sc_phase in reset", sc_phase, 0);
    chk("R1", "hd_pix in reset", hd_pix, 0);
    chk("R1", "hd_line in reset", hd_line, 0);
    phase_step = 32'h3000_0001;
    rst_n = 1'b1;

    // free run NTSC then PAL (R2, R3, R4 via model)
    repeat (200) @(negedge clk);
    pal_sel = 1'b1;
    phase_step = 32'h9E37_79B9;
    repeat (400) @(negedge clk);

    // R9: pin ignored in off and frequency-lock modes
    for (int md = 0; md < 2; md++) begin
      pin_mode = (md == 0) ? 2'b00 : 2'b11;
      ph0 = sc_phase;
      sync_pin = 1'b1;
      repeat (3) @(negedge clk);
      sync_pin = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9", "phase after ignored pulse", sc_phase, (ph0 + 8 * longint'(phase_step)) & 32'hFFFF_FFFF);
    end

    // R5 / R6: long hold in timing mode
    pin_mode = 2'b10;
    repeat (7) @(negedge clk);
    sync_pin = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      chk("R5", "held sd_pix", sd_pix, 0);
      chk("R5", "held sd_line", sd_line, 0);
      chk("R5", "held sd_field", sd_field, 1);
      chk("R5", "held sc_phase", sc_phase, 0);
      chk("R11", "hd_pix vs model during SD hold", hd_pix, m_hp);
      @(negedge clk);
    end
    sync_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6", "still held sd_pix", sd_pix, 0);
    chk("R6", "still held sc_phase", sc_phase, 0);
    @(negedge clk);
    chk("R6", "resumed sd_pix", sd_pix, 1);
    chk("R6", "resumed sd_field", sd_field, 1);
    chk("R6", "resumed sc_phase", sc_phase, phase_step);
    repeat (30) @(negedge clk);

    // R7: single-edge pulse
    sync_pin = 1'b1;
    @(negedge clk);
    sync_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", "short pulse sd_pix", sd_pix, 0);
    chk("R7", "short pulse sd_field", sd_field, 1);
    chk("R7", "short pulse sc_phase", sc_phase, 0);
    @(negedge clk);
    chk("R7", "after short pulse sd_pix", sd_pix, 1);
    chk("R7", "after short pulse sc_phase", sc_phase, phase_step);

    // R8: deferred phase clear, twice in PAL, once in NTSC
    for (int t = 0; t < 3; t++) begin
      pin_mode = 2'b01;
      if (t == 2) pal_sel = 1'b0;
      repeat (20) @(negedge clk);
      while (!(sd_pix == 0 && sd_line == 1)) @(negedge clk);
      sync_pin = 1'b1;
      @(negedge clk);
      sync_pin = 1'b0;
      f0 = sd_field;
      nf = pal_sel ? 8 : 4;
      for (int w = 0; w < 200 && sd_field == f0; w++) @(negedge clk);
      chk("R8", "phase at new field", sc_phase, 0);
      chk("R8", "field continues", sd_field, (f0 >= nf) ? 1 : f0 + 1);
      @(negedge clk);
      chk("R8", "phase accumulates again", sc_phase, phase_step);
    end

    // R10 / R11: HD hold
    pin_mode = 2'b00;
    repeat (9) @(negedge clk);
    hd_hold = 1'b1;
    ph0 = sc_phase;
    repeat (15) @(negedge clk);
    chk("R10", "hd_pix held", hd_pix, 0);
    chk("R10", "hd_line held", hd_line, 0);
    chk("R11", "sd_pix unaffected by hd hold", sd_pix, m_pix);
    chk("R11", "phase unaffected by hd hold", sc_phase, (ph0 + 15 * longint'(phase_step)) & 32'hFFFF_FFFF);
    hd_hold = 1'b0;
    @(negedge clk);
    chk("R10", "hd_pix resumes", hd_pix, 1);
    repeat (40) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule